// File: doc/BRIEF.md
# Windowed Address Translation Table

This block converts the address of a transaction arriving on one of several source ports into a translated address and a destination selector. Each source port has a small private group of table entries. Every entry describes one naturally aligned window of the source address space. It holds a source base, a translated base, a size code giving a power-of-two span, a destination selector and an enable flag. An entry may also be marked as a pass-through window, which accepts any address and forwards it unchanged.

Software programs the entries through a flat word-addressed register port with single-cycle writes and combinational reads. The transaction path presents a port number and an address on the lookup interface. One clock later the block returns a hit flag, the translated address and the destination selector. The source ports are numbered 0 to 5: ports 0 and 1 are host-side windows and ports 2 to 5 are on-chip slave ports.

Top module: `xlat_table`

## Requirements
- R1: After synchronous reset every entry is disabled and reads back as zero, `rsp_valid` is low, and every lookup misses.
- R2: The register word address is port*(4*TBL_PER_PORT) + table*4 + field. Field 0 is the source word: bit 0 is the enable, bits 6:1 are the size code, and bits 31:12 are the source base. Field 1 is the translated base, held in bits 31:12. Field 2 holds the destination selector in bits 2:0. Base bits 11:0, source-word bits 11:7 and destination-word bits 31:3 are dropped on write and read as zero.
- R3: An entry with size code c covers 2^(c+1) bytes. An address hits the entry when the address and the source base agree in every bit at or above bit c+1.
- R4: On a hit, `rsp_addr` is the translated base ORed with the address bits below bit c+1, and `rsp_dst` is the entry's destination selector. The selector values are 0 for host transaction, 1 for host configuration, and 4 to 7 for on-chip master ports 0 to 3.
- R5: Size code 63 marks a pass-through entry. When enabled, it hits on any address and returns that address unchanged, whatever translated base is stored.
- R6: Only the entries of the requested port are searched. When several enabled entries hit, the one with the lowest table index wins.
- R7: A lookup with no hit returns `rsp_hit`=0, with `rsp_addr` and `rsp_dst` both zero.
- R8: A lookup presented with `lk_valid` high in one cycle produces `rsp_valid` high in the next cycle. `rsp_valid` is low in the cycle after a cycle without a lookup.
- R9: A register write is seen by lookups presented from the next cycle on. A lookup in the same cycle as a write uses the entry contents from before the write.
- R10: Writing zero to an entry's source word disables the entry.
- R11: Writes to port numbers 6 and 7, or to field 3, change nothing and read back as zero. Lookups on port numbers 6 and 7 miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| lk_valid | input | 1 | Lookup request valid |
| lk_port | input | 3 | Source port of the lookup |
| lk_addr | input | 32 | Address to translate |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | An enabled entry matched |
| rsp_addr | output | 32 | Translated address, zero on miss |
| rsp_dst | output | 3 | Destination selector, zero on miss |

## Verification
A register write and a lookup can occur in the same clock cycle. The interesting case is a write that disables or reshapes the very entry the lookup would select. The bench triggers this by driving a zeroing write to the winning entry together with a lookup that hits that entry, and then repeating the lookup one cycle later. It expects the first response to come from the old contents and the second response to fall through to the next table entry.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int ADDR_W  = 32;
    localparam int ALIGN_W = 12;
    localparam int CODE_W  = 6;
    localparam int DST_W   = 3;
    localparam int FLD_W   = 2;

    localparam logic [CODE_W-1:0] CODE_PASS = '1;

    typedef enum logic [DST_W-1:0] {
        DST_HOST_TXN = 3'd0,
        DST_HOST_CFG = 3'd1,
        DST_MST0     = 3'd4,
        DST_MST1     = 3'd5,
        DST_MST2     = 3'd6,
        DST_MST3     = 3'd7
    } dst_e;

    typedef enum logic [FLD_W-1:0] {
        FLD_SRC   = 2'd0,
        FLD_TRSL  = 2'd1,
        FLD_PARAM = 2'd2,
        FLD_RSVD  = 2'd3
    } fld_e;

    typedef struct packed {
        logic                      en;
        logic [CODE_W-1:0]         code;
        logic [ADDR_W-1:ALIGN_W]   sbase;
        logic [ADDR_W-1:ALIGN_W]   tbase;
        logic [DST_W-1:0]          dst;
    } entry_t;

    // Mask of the bits below the window boundary: span is 2^(code+1).
    function automatic logic [ADDR_W-1:0] span_mask(input logic [CODE_W-1:0] code);
        logic [ADDR_W-1:0] m;
        int n;
        n = int'(code) + 1;
        m = '0;
        for (int i = 0; i < ADDR_W; i++) begin
            m[i] = (i < n);
        end
        return m;
    endfunction

    function automatic logic [ADDR_W-1:0] src_word(input entry_t e);
        return {e.sbase, {(ALIGN_W-1-CODE_W){1'b0}}, e.code, e.en};
    endfunction

    function automatic logic [ADDR_W-1:0] base_full(input logic [ADDR_W-1:ALIGN_W] b);
        return {b, {ALIGN_W{1'b0}}};
    endfunction

endpackage

// File: rtl/xlat_entry.sv
module xlat_entry
    import xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [FLD_W-1:0]  fld,
    input  logic [ADDR_W-1:0] wdata,
    input  logic [ADDR_W-1:0] lk_addr,
    output entry_t            st,
    output logic              match,
    output logic [ADDR_W-1:0] xaddr
);

    entry_t            st_q;
    logic              pass;
    logic [ADDR_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (we) begin
            case (fld_e'(fld))
                FLD_SRC: begin
                    st_q.en    <= wdata[0];
                    st_q.code  <= wdata[CODE_W:1];
                    st_q.sbase <= wdata[ADDR_W-1:ALIGN_W];
                end
                FLD_TRSL:  st_q.tbase <= wdata[ADDR_W-1:ALIGN_W];
                FLD_PARAM: st_q.dst   <= wdata[DST_W-1:0];
                default: ;
            endcase
        end
    end

    assign st = st_q;

    always_comb begin
        pass  = (st_q.code == CODE_PASS);
        mask  = span_mask(st_q.code);
        match = st_q.en &&
                (pass || ((lk_addr & ~mask) == (base_full(st_q.sbase) & ~mask)));
        xaddr = pass ? lk_addr : (base_full(st_q.tbase) | (lk_addr & mask));
    end

    // R10: a zero source word leaves the entry disabled
    a_r10_zero_disables: assert property (@(posedge clk) disable iff (rst)
        (we && fld == FLD_SRC && wdata == '0) |=> !st_q.en);

    // R9: contents only change after a write strobe
    a_r9_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(st_q));

endmodule

// File: rtl/xlat_pick.sv
module xlat_pick #(
    parameter int N     = 2,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             hit,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        hit   = 1'b0;
        grant = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit   = 1'b1;
                grant = '0;
                grant[i] = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

    // R6: at most one winner, and it is a requesting entry
    always_comb begin
        a_r6_single_grant: assert ($onehot0(grant));
        a_r6_grant_requested: assert ((grant & ~req) == '0);
    end

endmodule

// File: rtl/xlat_table.sv
module xlat_table
    import xlat_pkg::*;
#(
    parameter int NUM_PORTS    = 6,
    parameter int TBL_PER_PORT = 2,
    localparam int PORT_W = $clog2(NUM_PORTS + 1),
    localparam int TBL_W  = (TBL_PER_PORT > 1) ? $clog2(TBL_PER_PORT) : 1,
    localparam int REG_AW = PORT_W + TBL_W + FLD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              lk_valid,
    input  logic [PORT_W-1:0] lk_port,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [DST_W-1:0]  rsp_dst
);

    localparam int NUM_ENT = NUM_PORTS * TBL_PER_PORT;
    localparam logic [PORT_W-1:0] PORT_LIM = PORT_W'(NUM_PORTS);

    // register address split
    logic [PORT_W-1:0] w_port;
    logic [TBL_W-1:0]  w_tbl;
    logic [FLD_W-1:0]  w_fld;
    logic              w_port_ok;

    assign w_port    = reg_addr[REG_AW-1 -: PORT_W];
    assign w_tbl     = reg_addr[FLD_W +: TBL_W];
    assign w_fld     = reg_addr[FLD_W-1:0];
    assign w_port_ok = (w_port < PORT_LIM);

    entry_t            st_arr    [NUM_ENT];
    logic              match_arr [NUM_ENT];
    logic [ADDR_W-1:0] xaddr_arr [NUM_ENT];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        for (genvar t = 0; t < TBL_PER_PORT; t++) begin : g_tbl
            localparam int E = p * TBL_PER_PORT + t;
            logic ent_we;
            assign ent_we = reg_we && (w_port == PORT_W'(p)) && (w_tbl == TBL_W'(t));
            xlat_entry u_ent (
                .clk     (clk),
                .rst     (rst),
                .we      (ent_we),
                .fld     (w_fld),
                .wdata   (reg_wdata),
                .lk_addr (lk_addr),
                .st      (st_arr[E]),
                .match   (match_arr[E]),
                .xaddr   (xaddr_arr[E])
            );
        end
    end

    // register readback
    always_comb begin
        entry_t re;
        reg_rdata = '0;
        re = st_arr[0];
        if (w_port_ok) begin
            re = st_arr[int'(w_port) * TBL_PER_PORT + int'(w_tbl)];
            case (fld_e'(w_fld))
                FLD_SRC:   reg_rdata = src_word(re);
                FLD_TRSL:  reg_rdata = base_full(re.tbase);
                FLD_PARAM: reg_rdata = {{(ADDR_W-DST_W){1'b0}}, re.dst};
                default:   reg_rdata = '0;
            endcase
        end
    end

    // lookup: gather the matches of the requested port
    logic                    l_port_ok;
    logic [TBL_PER_PORT-1:0] port_req;
    logic                    sel_hit;
    logic [TBL_PER_PORT-1:0] sel_grant;
    logic [TBL_W-1:0]        sel_idx;
    logic [ADDR_W-1:0]       d_addr;
    logic [DST_W-1:0]        d_dst;

    assign l_port_ok = (lk_port < PORT_LIM);

    always_comb begin
        port_req = '0;
        if (l_port_ok) begin
            for (int t = 0; t < TBL_PER_PORT; t++) begin
                port_req[t] = match_arr[int'(lk_port) * TBL_PER_PORT + t];
            end
        end
    end

    xlat_pick #(.N(TBL_PER_PORT), .IDX_W(TBL_W)) u_pick (
        .req   (port_req),
        .hit   (sel_hit),
        .grant (sel_grant),
        .idx   (sel_idx)
    );

    always_comb begin
        int e;
        d_addr = '0;
        d_dst  = '0;
        e = 0;
        if (sel_hit && l_port_ok) begin
            e      = int'(lk_port) * TBL_PER_PORT + int'(sel_idx);
            d_addr = xaddr_arr[e];
            d_dst  = st_arr[e].dst;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_addr  <= '0;
            rsp_dst   <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && sel_hit;
            rsp_addr  <= (lk_valid && sel_hit) ? d_addr : '0;
            rsp_dst   <= (lk_valid && sel_hit) ? d_dst  : '0;
        end
    end

    // R1: reset clears the response
    a_r1_reset_idle: assert property (@(posedge clk) rst |=> !rsp_valid && !rsp_hit);

    // R8: one-cycle response timing
    a_r8_resp_follows: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid && !rsp_hit);

    // R7: a miss carries zero payload
    a_r7_miss_zero: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_addr == '0 && rsp_dst == '0));

    // R11: unknown ports never hit
    a_r11_bad_port_miss: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !(lk_port < PORT_LIM)) |=> !rsp_hit);

endmodule

// File: tb/xlat_table_tb_top.sv
module xlat_table_tb_top;
    import xlat_pkg::*;

    localparam int NP = 6;
    localparam int NT = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [2:0]  lk_port = '0;
    logic [31:0] lk_addr = '0;
    logic        rsp_valid, rsp_hit;
    logic [31:0] rsp_addr;
    logic [2:0]  rsp_dst;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    xlat_table #(.NUM_PORTS(NP), .TBL_PER_PORT(NT)) dut_i (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lk_valid(lk_valid), .lk_port(lk_port), .lk_addr(lk_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr), .rsp_dst(rsp_dst)
    );

    // bench model of the table, built from the requirements
    bit          m_en   [NP*NT];
    logic [5:0]  m_code [NP*NT];
    logic [31:0] m_src  [NP*NT];
    logic [31:0] m_trs  [NP*NT];
    logic [2:0]  m_dst  [NP*NT];

    bit          q_hit [$];
    logic [31:0] q_addr[$];
    logic [2:0]  q_dst [$];
    string       q_tag [$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model_lookup(input int p, input logic [31:0] a,
                                         output bit h, output logic [31:0] oa, output logic [2:0] od);
        h = 0; oa = '0; od = '0;
        if (p < NP) begin
            for (int t = NT - 1; t >= 0; t--) begin
                int e;
                int n;
                logic [31:0] mask;
                bit pass;
                e = p * NT + t;
                n = int'(m_code[e]) + 1;
                mask = (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
                pass = (m_code[e] == 6'd63);
                if (m_en[e] && (pass || ((a & ~mask) == (m_src[e] & ~mask)))) begin
                    h  = 1;
                    oa = pass ? a : (m_trs[e] | (a & mask));
                    od = m_dst[e];
                end
            end
        end
    endfunction

    function automatic void model_write(input int p, input int t, input int f, input logic [31:0] d);
        int e;
        e = p * NT + t;
        if (p < NP) begin
            case (f)
                0: begin m_en[e] = d[0]; m_code[e] = d[6:1]; m_src[e] = d & 32'hFFFF_F000; end
                1: m_trs[e] = d & 32'hFFFF_F000;
                2: m_dst[e] = d[2:0];
                default: ;
            endcase
        end
    endfunction

    // driver: one cycle with optional write and optional lookup
    task automatic cyc(input bit we, input int wp, input int wt, input int wf, input logic [31:0] wd,
                       input bit lv, input int lp, input logic [31:0] la, input string tag);
        bit h; logic [31:0] oa; logic [2:0] od;
        @(negedge clk);
        if (lv) begin
            model_lookup(lp, la, h, oa, od);
            q_hit.push_back(h); q_addr.push_back(oa); q_dst.push_back(od); q_tag.push_back(tag);
        end
        if (we) model_write(wp, wt, wf, wd);
        reg_we    = we;
        reg_addr  = 6'(wp * NT * 4 + wt * 4 + wf);
        reg_wdata = wd;
        lk_valid  = lv;
        lk_port   = 3'(lp);
        lk_addr   = la;
    endtask

    task automatic wr(input int p, input int t, input int f, input logic [31:0] d);
        cyc(1'b1, p, t, f, d, 1'b0, 0, '0, "");
    endtask

    task automatic look(input int p, input logic [31:0] a, input string tag);
        cyc(1'b0, 0, 0, 0, '0, 1'b1, p, a, tag);
    endtask

    task automatic rd(input int p, input int t, input int f, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_we = 1'b0; lk_valid = 1'b0;
        reg_addr = 6'(p * NT * 4 + t * 4 + f);
        #1;
        chk(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    // monitor: compare each response with the oldest expectation
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (q_hit.size() == 0) begin
                chk(1'b0, "R8 unexpected response", {31'b0, rsp_valid}, 32'h0);
            end else begin
                bit h; logic [31:0] a; logic [2:0] d; string tg;
                h = q_hit.pop_front(); a = q_addr.pop_front();
                d = q_dst.pop_front(); tg = q_tag.pop_front();
                chk(rsp_hit == h, {tg, " hit"}, {31'b0, rsp_hit}, {31'b0, h});
                chk(rsp_addr == a, {tg, " addr"}, rsp_addr, a);
                chk(rsp_dst == d, {tg, " dst"}, {29'b0, rsp_dst}, {29'b0, d});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int e = 0; e < NP * NT; e++) begin
            m_en[e] = 0; m_code[e] = '0; m_src[e] = '0; m_trs[e] = '0; m_dst[e] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state
        chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
        rd(0, 0, 0, 32'h0, "R1 source word after reset");
        rd(5, 1, 1, 32'h0, "R1 translated base after reset");
        look(0, 32'h0000_1234, "R1 lookup after reset");

        // R2: programming and readback masking
        wr(0, 0, 0, 32'h4000_0F97);          // base 0x40000000, code 11, enabled
        wr(0, 0, 1, 32'h8000_0ABC);
        wr(0, 0, 2, 32'hFFFF_FFFC);          // selector 4
        rd(0, 0, 0, 32'h4000_0017, "R2 source word readback");
        rd(0, 0, 1, 32'h8000_0000, "R2 translated base readback");
        rd(0, 0, 2, 32'h0000_0004, "R2 selector readback");

        // R3/R4: window hit, boundaries
        look(0, 32'h4000_0123, "R4 hit inside window");
        look(0, 32'h4000_1000, "R3 just above window");
        look(0, 32'h3FFF_FFFF, "R3 just below window");
        look(0, 32'h4000_0FFF, "R3 last byte of window");

        // R6: overlapping entries, lowest index wins
        wr(0, 1, 0, 32'h4000_001F);          // code 15, span 64 KiB
        wr(0, 1, 1, 32'h9000_0000);
        wr(0, 1, 2, 32'h0000_0005);
        look(0, 32'h4000_0010, "R6 lower index wins");
        look(0, 32'h4000_2010, "R6 second entry only");
        look(1, 32'h4000_0010, "R6 other port unaffected");

        // R5: pass-through window with a stored translated base
        wr(2, 0, 1, 32'h1234_5000);
        wr(2, 0, 2, 32'h0000_0000);
        wr(2, 0, 0, 32'h0000_007F);
        look(2, 32'hDEAD_BEEF, "R5 pass-through keeps address");
        look(2, 32'h0000_0001, "R5 pass-through low address");

        // R3: smallest window on the last entry
        wr(5, 1, 0, 32'hABCD_E001);          // code 0, span 2
        wr(5, 1, 1, 32'h0002_0000);
        wr(5, 1, 2, 32'h0000_0007);
        look(5, 32'hABCD_E001, "R3 two-byte window hit");
        look(5, 32'hABCD_E002, "R3 two-byte window miss");

        // R9/R10: write and lookup in the same cycle
        cyc(1'b1, 0, 0, 0, 32'h0, 1'b1, 0, 32'h4000_0010, "R9 same-cycle lookup sees old entry");
        look(0, 32'h4000_0010, "R10 disabled entry falls through");
        rd(0, 0, 0, 32'h0, "R10 zero source word readback");

        // R8: back-to-back stream then idle
        look(0, 32'h4000_0020, "R8 stream 0");
        look(1, 32'h0000_0000, "R8 stream 1 miss");
        look(2, 32'h0BAD_F00D, "R8 stream 2");
        @(negedge clk); lk_valid = 1'b0; reg_we = 1'b0;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R8 idle after stream", {31'b0, rsp_valid}, 32'h0);

        // R11: nonexistent ports and reserved field
        wr(6, 0, 0, 32'h0000_007F);
        wr(7, 1, 2, 32'h0000_0006);
        wr(0, 1, 3, 32'hFFFF_FFFF);
        rd(6, 0, 0, 32'h0, "R11 port 6 reads zero");
        rd(0, 1, 3, 32'h0, "R11 reserved field reads zero");
        rd(0, 1, 0, 32'h4000_001F, "R11 neighbour word untouched");
        look(6, 32'h1234_5678, "R11 lookup on port 6");
        look(7, 32'h1234_5678, "R11 lookup on port 7");

        @(negedge clk); lk_valid = 1'b0; reg_we = 1'b0;
        repeat (3) @(negedge clk);
        chk(q_hit.size() == 0, "R8 all responses delivered", 32'(q_hit.size()), 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule